// File: doc/BRIEF.md
# Interrupt Request and Level Register

This block is the control register for one interrupt source of a peripheral interrupt controller. It keeps a one-bit pending flag and a three-bit priority level. It watches one request line from a peripheral. A mode input tells the block whether that line is edge-recognized (a 0-to-1 change raises the flag) or level-recognized (the flag mirrors the line).

Software reaches the register through a byte-wide bus port. Reads are combinational and writes take effect on the next clock edge. A separate strobe tells the block that the vector register was read for this source. In edge mode that strobe acknowledges the request.

The block gives the priority resolver two outputs: the level, and a request line. The request line is active only for a pending source whose level is not the disabled level.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset the register reads 0x07 (flag 0, level 7), `req_out` is 0 and `prio_out` is 7.
- R2: While `bus_sel` is 1, `bus_rdata` returns the flag in bit 4 and the level in bits 2..0 in the same cycle, with bits 7..5 and bit 3 at 0. While `bus_sel` is 0, `bus_rdata` is 0x00.
- R3: A write (`bus_sel` and `bus_wr` both 1) loads `bus_wdata[2:0]` into the level at the next clock edge. This holds in either source mode.
- R4: In edge mode (`mode_level` = 0), a 0-to-1 change of `src_in` sets the flag on the third rising clock edge after the input changes. The input staying high does not set the flag again after it is cleared.
- R5: In edge mode, a write with `bus_wdata[4]` = 1 sets the flag and a write with `bus_wdata[4]` = 0 clears it.
- R6: In level mode (`mode_level` = 1), the flag follows `src_in` with the same three-edge latency. Writes to bit 4 have no effect on it.
- R7: In edge mode, a pulse on `vec_rd` clears the flag at the next edge. In level mode, `vec_rd` has no effect.
- R8: In edge mode, a software clear in the same cycle as a detected input edge leaves the flag at 0.
- R9: In edge mode, a `vec_rd` pulse in the same cycle as a detected input edge leaves the flag at 0.
- R10: `prio_out` equals the level. `req_out` is 1 exactly when the flag is 1 and the level is not 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_in | input | 1 | Raw request line from the peripheral (asynchronous) |
| mode_level | input | 1 | Source type: 0 = edge-recognized, 1 = level-recognized |
| bus_sel | input | 1 | Register selected for access |
| bus_wr | input | 1 | Write strobe (valid with `bus_sel`) |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte |
| vec_rd | input | 1 | Vector register was read for this source |
| req_out | output | 1 | Active request toward the priority resolver |
| prio_out | output | 3 | Priority level toward the priority resolver |

## Verification
A wrong pending flag is visible on the very next bus read through bit 4. It also shows on `req_out` in the same cycle, unless the level is 7. A flag that was set but not cleared on `vec_rd` or a software clear shows one cycle after the strobe. A missed or doubled edge detection shows on the third edge after the input change. A level register that ignores a write appears on `prio_out` and on bits 2..0 of the read one cycle after that write.

// File: rtl/irq_ctl_pkg.sv
// Package irq_ctl_pkg
// Shared constants and types for the per-source interrupt control register.
// Assumes a byte-wide software view with a single pending bit and a
// binary-coded priority whose all-ones value disables the source.
package irq_ctl_pkg;

    localparam int BYTE_W   = 8;
    localparam int PRIO_W   = 3;
    localparam int FLAG_BIT = 4;
    localparam int SYNC_N   = 2;

    // Highest encoding means "source disabled"; it is also the reset level.
    localparam logic [PRIO_W-1:0] PRIO_OFF = {PRIO_W{1'b1}};

    typedef enum logic {
        SRC_EDGE  = 1'b0,
        SRC_LEVEL = 1'b1
    } src_mode_e;

    // Software command toward the pending flag.
    typedef struct packed {
        logic wr;   // write of the flag bit this cycle
        logic val;  // written value
    } flag_cmd_t;

endpackage

// File: rtl/irq_in_sync.sv
// Module irq_in_sync
// Brings the asynchronous peripheral request into the clock domain through
// STAGES flops and flags a 0-to-1 change of the synchronized level.
// Assumes STAGES >= 1; rise_o is a one-cycle pulse.
module irq_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_in,
    output logic lvl_o,
    output logic rise_o
);

    logic [STAGES-1:0] stg_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= src_in;
            end
        end else begin : g_chain
            // Shift chain of capture stages.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[STAGES-2:0], src_in};
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= stg_q[STAGES-1];
    end

    assign lvl_o  = stg_q[STAGES-1];
    assign rise_o = stg_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/irq_pend_flag.sv
// Module irq_pend_flag
// Holds the pending flag of one interrupt source.
// Edge mode: clears (software 0-write or vector read) beat sets (software
// 1-write or detected rise). Level mode: the flag mirrors the synchronized
// input, and software writes and vector reads are ignored.
module irq_pend_flag
    import irq_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  src_mode_e mode,
    input  logic      lvl_i,
    input  logic      rise_i,
    input  flag_cmd_t cmd,
    input  logic      vec_rd,
    output logic      pend_o
);

    logic pend_q;
    logic pend_d;
    logic clr_req;
    logic set_req;

    // Collect clear and set causes for edge mode.
    always_comb begin
        clr_req = (cmd.wr && !cmd.val) || vec_rd;
        set_req = (cmd.wr &&  cmd.val) || rise_i;
    end

    // Next-state selection with clear priority.
    always_comb begin
        pend_d = pend_q;
        case (mode)
            SRC_LEVEL: pend_d = lvl_i;
            default: begin
                if (clr_req)      pend_d = 1'b0;
                else if (set_req) pend_d = 1'b1;
            end
        endcase
    end

    // Flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_reg.sv
// Module irq_prio_reg
// Software-writable priority level of one source, reset to RST_VAL.
// Assumes wr_en is already qualified by select and write strobe.
module irq_prio_reg #(
    parameter int              W       = 3,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] level_o
);

    logic [W-1:0] level_q;

    // Level storage, loaded on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)     level_q <= RST_VAL;
        else if (wr_en) level_q <= wdata;
    end

    assign level_o = level_q;

endmodule

// File: rtl/irq_src_ctrl.sv
// Module irq_src_ctrl
// Per-source interrupt control register: pending flag plus priority level,
// a byte-wide software view, and request/level outputs toward a resolver.
// Assumes bus_wr is only meaningful while bus_sel is high, and vec_rd is a
// single-cycle strobe aimed at this source.
module irq_src_ctrl
    import irq_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_in,
    input  logic              mode_level,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              vec_rd,
    output logic              req_out,
    output logic [PRIO_W-1:0] prio_out
);

    src_mode_e         mode;
    logic              wr_hit;
    flag_cmd_t         cmd;
    logic              sync_lvl;
    logic              sync_rise;
    logic              pend_q;
    logic [PRIO_W-1:0] level;
    logic              unused_wbits;

    // Decode mode and the software command; flag writes only count in edge mode.
    always_comb begin
        mode    = src_mode_e'(mode_level);
        wr_hit  = bus_sel && bus_wr;
        cmd.wr  = wr_hit && (mode == SRC_EDGE);
        cmd.val = bus_wdata[FLAG_BIT];
    end

    assign unused_wbits = ^{bus_wdata[BYTE_W-1:FLAG_BIT+1],
                            bus_wdata[FLAG_BIT-1:PRIO_W]};

    irq_in_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_in),
        .lvl_o  (sync_lvl),
        .rise_o (sync_rise)
    );

    irq_pend_flag flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .lvl_i  (sync_lvl),
        .rise_i (sync_rise),
        .cmd    (cmd),
        .vec_rd (vec_rd),
        .pend_o (pend_q)
    );

    irq_prio_reg #(
        .W       (PRIO_W),
        .RST_VAL (PRIO_OFF)
    ) prio_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_hit),
        .wdata   (bus_wdata[PRIO_W-1:0]),
        .level_o (level)
    );

    // Assemble the software view; unselected reads return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            bus_rdata[FLAG_BIT]   = pend_q;
            bus_rdata[PRIO_W-1:0] = level;
        end
    end

    // Outputs toward the priority resolver; the disabled level masks the request.
    always_comb begin
        prio_out = level;
        req_out  = pend_q && (level != PRIO_OFF);
    end

endmodule

// File: rtl/irq_src_ctrl_chk.sv
// Module irq_src_ctrl_chk
// Protocol and priority checks for irq_src_ctrl, attached with bind.
module irq_src_ctrl_chk
    import irq_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_level,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              vec_rd,
    input logic              req_out,
    input logic [PRIO_W-1:0] prio_out,
    input logic              pend_q,
    input logic              sync_lvl
);

    // R10
    disabled_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_out == PRIO_OFF) |-> !req_out);

    // R3
    prio_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr) |=> (prio_out == $past(bus_wdata[PRIO_W-1:0])));

    // R8
    sw_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_wdata[FLAG_BIT] && !mode_level) |=> !pend_q);

    // R9
    vec_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !mode_level) |=> !pend_q);

    // R6
    level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_level |=> (pend_q == $past(sync_lvl)));

    // R2
    rdata_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |-> (bus_rdata[BYTE_W-1:FLAG_BIT+1] == '0 && !bus_rdata[PRIO_W]));

    // R2
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0));

    // R10
    req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_out |-> (bus_sel ? bus_rdata[FLAG_BIT] : 1'b1));

endmodule

bind irq_src_ctrl irq_src_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_level (mode_level),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .vec_rd     (vec_rd),
    .req_out    (req_out),
    .prio_out   (prio_out),
    .pend_q     (pend_q),
    .sync_lvl   (sync_lvl)
);

// File: tb/irq_src_ctrl_tb_top.sv
// Scoreboard bench: driver tasks push expected items into a queue,
// a monitor process pops and compares them after each falling edge.
module irq_src_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_in = 1'b0;
    logic       mode_level = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       vec_rd = 1'b0;
    logic       req_out;
    logic [2:0] prio_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] rdata;
        logic       req;
        logic [2:0] prio;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    irq_src_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_in     (src_in),
        .mode_level (mode_level),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .vec_rd     (vec_rd),
        .req_out    (req_out),
        .prio_out   (prio_out)
    );

    // Monitor: compare outputs 2 ns after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (bus_rdata !== e.rdata || req_out !== e.req || prio_out !== e.prio) begin
                    errors++;
                    $display("FAIL %s: rdata=%02h req=%b prio=%0d expected rdata=%02h req=%b prio=%0d",
                             e.tag, bus_rdata, req_out, prio_out, e.rdata, e.req, e.prio);
                end
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Read with select; flag/level model gives req and prio.
    task automatic expect_reg(input logic [7:0] flag_lvl, input string tag);
        exp_t e;
        bus_sel = 1'b1;
        bus_wr  = 1'b0;
        e.rdata = flag_lvl;
        e.prio  = flag_lvl[2:0];
        e.req   = flag_lvl[4] && (flag_lvl[2:0] != 3'd7);
        e.tag   = tag;
        sb_q.push_back(e);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Idle read: no select, data must be zero.
    task automatic expect_idle(input logic [7:0] flag_lvl, input string tag);
        exp_t e;
        e.rdata = 8'h00;
        e.prio  = flag_lvl[2:0];
        e.req   = flag_lvl[4] && (flag_lvl[2:0] != 3'd7);
        e.tag   = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] d);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = 8'h00;
    endtask

    task automatic vec_pulse();
        vec_rd = 1'b1;
        @(negedge clk);
        vec_rd = 1'b0;
    endtask

    // Driver: stimulus sequence.
    initial begin
        tick(3);
        rst_n = 1'b1;

        expect_reg(8'h07, "R1 reset value");
        expect_idle(8'h07, "R2 unselected read is zero");

        bus_write(8'hE2);
        expect_reg(8'h02, "R3 level write, R2 spare bits zero");

        bus_write(8'h13);
        expect_reg(8'h13, "R5 software set, R10 request active");
        bus_write(8'h03);
        expect_reg(8'h03, "R5 software clear");

        // R4 edge detection latency
        src_in = 1'b1;
        tick(2);
        expect_reg(8'h03, "R4 flag not yet set");
        expect_reg(8'h13, "R4 flag set on third edge");
        bus_write(8'h03);
        tick(4);
        expect_reg(8'h03, "R4 steady high does not re-set");

        // R7 vector read clears in edge mode
        src_in = 1'b0;
        tick(3);
        src_in = 1'b1;
        tick(1);
        src_in = 1'b0;
        tick(4);
        expect_reg(8'h13, "R4 short pulse sets flag");
        vec_pulse();
        expect_reg(8'h03, "R7 vector read clears in edge mode");

        // R8 software clear collides with detected edge
        tick(3);
        src_in = 1'b1;
        tick(2);
        bus_write(8'h03);
        expect_reg(8'h03, "R8 clear wins over edge");
        tick(3);
        expect_reg(8'h03, "R8 flag stays clear");

        // R9 vector read collides with detected edge
        src_in = 1'b0;
        tick(4);
        src_in = 1'b1;
        tick(2);
        vec_pulse();
        expect_reg(8'h03, "R9 vector clear wins over edge");

        // R10 disabled level masks request
        bus_write(8'h17);
        expect_reg(8'h17, "R10 level 7 masks request");
        bus_write(8'h15);
        expect_reg(8'h15, "R10 level 5 forwards request");

        // R6 level mode
        src_in = 1'b0;
        tick(4);
        mode_level = 1'b1;
        tick(2);
        expect_reg(8'h05, "R6 flag follows low input");
        bus_write(8'h16);
        expect_reg(8'h06, "R6 flag write ignored, R3 level written");
        src_in = 1'b1;
        tick(2);
        expect_reg(8'h06, "R6 flag not yet high");
        expect_reg(8'h16, "R6 flag follows high input");
        bus_write(8'h06);
        expect_reg(8'h16, "R6 flag clear ignored");
        vec_pulse();
        expect_reg(8'h16, "R7 vector read ignored in level mode");
        src_in = 1'b0;
        tick(2);
        expect_reg(8'h16, "R6 flag still high");
        expect_reg(8'h06, "R6 flag follows input down");

        tick(2);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule